// File: doc/BRIEF.md
# Two-Wire Indexed Block Configuration Register Slave

This block is a serial slave on a two-wire bus (SCL clock, SDA data, open-drain). It gives a host access to a small bank of 8-bit configuration registers. The host names a starting index and a byte count, then moves a run of bytes in one transfer. SCL and SDA are sampled in the system clock domain through a synchronizer. The block detects start, repeated start and stop conditions, decodes the device address and walks the register index. It pulls SDA low through an output enable. The pad and the pull-up are outside the block.

A write transfer carries the index, the count and then the data bytes. A read transfer sets the index with a write header, then issues a repeated start with the read address. The slave answers with the bank size as a count byte, then returns registers from the index onward. Some register bits are read-only. They show the value on a status input, and host writes to them have no effect. The register contents are always visible to the rest of the device on a flat output bus.

Top module: `twsi_cfg_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0xD4 (write) or 0xD5 (read), which is 7-bit address 0x6A with bit 0 as the direction bit. On any other address it leaves SDA released, and it ignores every byte that follows until the next start condition.
- R2: A write transfer is address 0xD4, index N, count X, then X data bytes. Every byte is acknowledged, and data byte k lands in register N+k.
- R3: A data byte received after X bytes have been stored is not acknowledged and is not stored. The slave then ignores the bus until the next start.
- R4: After a repeated start and address 0xD5, the first byte the slave sends is the count 0x07 (the number of registers). After that it sends the registers in turn, starting at the index written in the header. Bytes go MSB first.
- R5: After register 6 (or any index of 7 or more), the running index wraps to 0. This applies to writes and to reads.
- R6: When the host does not acknowledge a byte it has read, the slave releases SDA and drives nothing until the next start. SDA then reads back as all ones.
- R7: Register 6 as a whole, and bits 5:4 of register 1, are read-only. They show the matching bits of `ro_in`, and writes to them have no effect. Such a write is still acknowledged.
- R8: A stop or start condition in the middle of a transfer ends it. Bytes stored before it stay stored. A start begins a new address phase at once.
- R9: The SDA enable changes only while SCL is low. It never changes during an SCL high phase.
- R10: After reset, SDA is released. With writable bits at their reset values, `cfg_q` reads back as register 0 = 0x21, register 1 = 0xCF, registers 2 to 5 = 0xFF. The read-only bits come from `ro_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low |
| ro_in | input | 56 | Read-only bit values, register k in bits 8k+7:8k |
| cfg_q | output | 56 | Register contents, register k in bits 8k+7:8k |

## Verification
A pin change on SCL or SDA passes two synchronizer flops and an edge register before the state machine acts on it. So `sda_oe` moves on the third clock edge after the SCL falling edge that triggers it. A stored byte shows on `cfg_q` on the fourth edge after the falling edge that ends that byte. The bench host holds each SCL quarter period for eight system clocks. It samples acknowledges and read bits in the middle of the SCL high phase and checks `cfg_q` only after the stop condition, so every result has settled well before it is sampled. A bench monitor counts any `sda_oe` change seen once SCL has been high for more than the synchronizer delay.

// File: rtl/twsi_pkg.sv
package twsi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_DATA
  } phase_t;

  // advance a register index, wrapping past the last implemented one
  function automatic logic [7:0] wrap_inc(input logic [7:0] cur, input logic [7:0] last);
    return (cur >= last) ? 8'd0 : cur + 8'd1;
  endfunction

endpackage

// File: rtl/twsi_sync.sv
module twsi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_p;
  logic              sda_p;

  // idle bus level is high, so reset the chain high to avoid false events
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twsi_fsm.sv
module twsi_fsm
  import twsi_pkg::*;
#(
  parameter int         NUM_REGS = 7,
  parameter logic [6:0] DEV_ADDR = 7'h6A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe,
  output state_t     st_o
);
  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);
  localparam logic [7:0] LAST_IDX   = 8'(NUM_REGS - 1);

  state_t     st;
  phase_t     ph;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] idx;
  logic [7:0] cnt;
  logic       rd_dir;
  logic       host_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ph       <= PH_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      idx      <= '0;
      cnt      <= '0;
      rd_dir   <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        st     <= ST_RX;
        ph     <= PH_ADDR;
        bitcnt <= '0;
        rd_dir <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              case (ph)
                PH_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    rd_dir <= shreg[0];
                    ph     <= PH_INDEX;
                    sda_oe <= 1'b1;
                    st     <= ST_RX_ACK;
                  end else begin
                    st <= ST_IGNORE;
                  end
                end
                PH_INDEX: begin
                  idx    <= shreg;
                  ph     <= PH_COUNT;
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end
                PH_COUNT: begin
                  cnt    <= shreg;
                  ph     <= PH_DATA;
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end
                default: begin
                  if (cnt != 8'd0) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= idx;
                    wr_data <= shreg;
                    idx     <= wrap_inc(idx, LAST_IDX);
                    cnt     <= cnt - 8'd1;
                    sda_oe  <= 1'b1;
                    st      <= ST_RX_ACK;
                  end else begin
                    st <= ST_IGNORE;
                  end
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_dir) begin
                shreg  <= COUNT_BYTE;
                sda_oe <= ~COUNT_BYTE[7];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_TX_ACK;
              end else begin
                bitcnt <= bitcnt + 4'd1;
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                idx    <= wrap_inc(idx, LAST_IDX);
                bitcnt <= '0;
                st     <= ST_TX;
              end else begin
                st <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_idx = idx;
  assign st_o   = st;

endmodule

// File: rtl/twsi_regbank.sv
module twsi_regbank #(
  parameter int                      NUM_REGS = 7,
  parameter logic [NUM_REGS*8-1:0]   RST_VAL  = 56'h00FFFFFFFFCF21,
  parameter logic [NUM_REGS*8-1:0]   RO_MASK  = 56'hFF000000003000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  output logic [7:0]            rd_data,
  input  logic [NUM_REGS*8-1:0] ro_in,
  output logic [NUM_REGS*8-1:0] cfg_q
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] MASK = RO_MASK[g*8 +: 8];
    logic [7:0] store;

    // only writable bits are held; read-only bits come straight from ro_in
    always_ff @(posedge clk) begin
      if (rst) begin
        store <= RST_VAL[g*8 +: 8] & ~MASK;
      end else if (wr_en && wr_idx == 8'(g)) begin
        store <= wr_data & ~MASK;
      end
    end

    assign cfg_q[g*8 +: 8] = store | (ro_in[g*8 +: 8] & MASK);
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == 8'(i)) rd_data = cfg_q[i*8 +: 8];
    end
  end

endmodule

// File: rtl/twsi_cfg_slave.sv
module twsi_cfg_slave
  import twsi_pkg::*;
#(
  parameter int                    NUM_REGS    = 7,
  parameter logic [6:0]            DEV_ADDR    = 7'h6A,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] RST_VAL     = 56'h00FFFFFFFFCF21,
  parameter logic [NUM_REGS*8-1:0] RO_MASK     = 56'hFF000000003000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic [NUM_REGS*8-1:0] ro_in,
  output logic [NUM_REGS*8-1:0] cfg_q
);
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_ev;
  logic       stop_ev;
  logic [7:0] rd_idx;
  logic [7:0] rd_data;
  logic       wr_en;
  logic [7:0] wr_idx;
  logic [7:0] wr_data;
  state_t     st;

  twsi_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  twsi_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe),
    .st_o     (st)
  );

  twsi_regbank #(.NUM_REGS(NUM_REGS), .RST_VAL(RST_VAL), .RO_MASK(RO_MASK)) i_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .ro_in   (ro_in),
    .cfg_q   (cfg_q)
  );

endmodule

// File: rtl/twsi_cfg_slave_chk.sv
module twsi_cfg_slave_chk
  import twsi_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   scl_s,
  input logic   scl_fall,
  input logic   start_ev,
  input logic   stop_ev,
  input logic   sda_oe,
  input logic   wr_en,
  input state_t st
);

  // R9: the SDA enable holds across an SCL high phase
  a_r9_oe_stable_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));

  // R8: a stop condition leaves SDA released
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (rst)
    $past(stop_ev) |-> !sda_oe);

  // R1: no drive while idle or ignoring the bus
  a_r1_no_drive_when_ignoring: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (st != ST_IDLE && st != ST_IGNORE));

  // R2: a register write coincides with the acknowledge that follows a falling SCL edge
  a_r2_write_with_ack: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(scl_fall) && sda_oe));

endmodule

bind twsi_cfg_slave twsi_cfg_slave_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_s    (scl_s),
  .scl_fall (scl_fall),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .sda_oe   (sda_oe),
  .wr_en    (wr_en),
  .st       (st)
);

// File: tb/test_twsi_cfg_slave.sv
module test_twsi_cfg_slave;
  localparam int Q = 8;  // system clocks per SCL quarter period
  localparam logic [55:0] RO_VAL = 56'h5A000000001000;
  localparam logic [7:0]  MASKS [7] = '{8'h00, 8'h30, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF};
  // idx, write data, expected register value
  localparam logic [23:0] VEC [6] = '{
    24'h00_A5_A5, 24'h01_00_10, 24'h01_FF_DF,
    24'h06_33_5A, 24'h05_3C_3C, 24'h03_81_81};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_host = 1'b1;
  logic sda_oe;
  logic [55:0] cfg_q;
  wire  sda_line = sda_host & ~sda_oe;

  int n_checks = 0;
  int n_fail = 0;
  int oe_viol = 0;
  int scl_hi = 0;
  logic oe_prev = 1'b0;
  logic [7:0] model [7];

  always #5 clk = ~clk;

  twsi_cfg_slave i_twsi_cfg_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .ro_in(RO_VAL), .cfg_q(cfg_q));

  // R9 monitor: enable must not move once SCL is settled high
  always @(negedge clk) begin
    if (scl) scl_hi <= scl_hi + 1; else scl_hi <= 0;
    if (!rst && scl && scl_hi >= 4 && sda_oe !== oe_prev) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_host = 1'b1; wq(1);
    scl = 1'b1;      wq(1);
    sda_host = 1'b0; wq(1);
    scl = 1'b0;      wq(1);
  endtask

  task automatic bus_stop();
    sda_host = 1'b0; wq(1);
    scl = 1'b1;      wq(1);
    sda_host = 1'b1; wq(1);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_host = b[i]; wq(1);
      scl = 1'b1;      wq(2);
      scl = 1'b0;      wq(1);
    end
    sda_host = 1'b1; wq(1);
    scl = 1'b1;      wq(1);
    ack = ~sda_line; wq(1);
    scl = 1'b0;      wq(1);
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    sda_host = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1);
      scl = 1'b1; wq(1);
      b[i] = sda_line; wq(1);
      scl = 1'b0;
    end
    wq(1);
    sda_host = ~give_ack; wq(1);
    scl = 1'b1;           wq(2);
    scl = 1'b0;           wq(1);
    sda_host = 1'b1;
  endtask

  function automatic logic [7:0] reg_of(input int k);
    return cfg_q[k*8 +: 8];
  endfunction

  function automatic logic [7:0] merge(input int k, input logic [7:0] d);
    return (d & ~MASKS[k]) | (model[k] & MASKS[k]);
  endfunction

  initial begin
    logic a;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R10 reset state
    model = '{8'h21, 8'hDF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h5A};
    chk("R10", "sda_oe after reset", 64'(sda_oe), 64'd0);
    for (int k = 0; k < 7; k++) chk("R10", "reset register", 64'(reg_of(k)), 64'(model[k]));

    // vector table: single-byte writes (R2, R7)
    for (int v = 0; v < 6; v++) begin
      bus_start();
      put_byte(8'hD4, a);        chk("R1", "write address ack", 64'(a), 64'd1);
      put_byte(VEC[v][23:16], a); chk("R2", "index ack", 64'(a), 64'd1);
      put_byte(8'd1, a);          chk("R2", "count ack", 64'(a), 64'd1);
      put_byte(VEC[v][15:8], a);  chk("R2", "data ack", 64'(a), 64'd1);
      bus_stop();
      chk("R7", "register after write", 64'(reg_of(int'(VEC[v][23:16]))), 64'(VEC[v][7:0]));
      model[int'(VEC[v][23:16])] = merge(int'(VEC[v][23:16]), VEC[v][15:8]);
    end

    // block write across read-only register 6 with wrap to 0 (R2, R5, R7)
    bus_start();
    put_byte(8'hD4, a); put_byte(8'h05, a); put_byte(8'h03, a);
    put_byte(8'h11, a); chk("R2", "block byte 0 ack", 64'(a), 64'd1);
    put_byte(8'h22, a); chk("R7", "read-only write ack", 64'(a), 64'd1);
    put_byte(8'h33, a); chk("R5", "wrapped byte ack", 64'(a), 64'd1);
    bus_stop();
    chk("R2", "reg5", 64'(reg_of(5)), 64'h11);
    chk("R7", "reg6 untouched", 64'(reg_of(6)), 64'h5A);
    chk("R5", "reg0 after wrap", 64'(reg_of(0)), 64'h33);

    // byte past the count (R3)
    bus_start();
    put_byte(8'hD4, a); put_byte(8'h02, a); put_byte(8'h01, a);
    put_byte(8'h44, a); chk("R3", "last counted byte ack", 64'(a), 64'd1);
    put_byte(8'h55, a); chk("R3", "extra byte nack", 64'(a), 64'd0);
    bus_stop();
    chk("R3", "reg2", 64'(reg_of(2)), 64'h44);
    chk("R3", "reg3 untouched", 64'(reg_of(3)), 64'h81);

    // foreign address (R1)
    bus_start();
    put_byte(8'hA4, a); chk("R1", "foreign address nack", 64'(a), 64'd0);
    put_byte(8'h00, a); chk("R1", "ignored index nack", 64'(a), 64'd0);
    put_byte(8'h01, a);
    put_byte(8'h77, a); chk("R1", "ignored data nack", 64'(a), 64'd0);
    bus_stop();
    chk("R1", "reg0 unchanged", 64'(reg_of(0)), 64'h33);

    // block read from index 4 with wrap (R4, R5, R6)
    bus_start();
    put_byte(8'hD4, a); put_byte(8'h04, a);
    bus_start();
    put_byte(8'hD5, a); chk("R1", "read address ack", 64'(a), 64'd1);
    get_byte(1'b1, b);  chk("R4", "count byte", 64'(b), 64'h07);
    get_byte(1'b1, b);  chk("R4", "read reg4", 64'(b), 64'hFF);
    get_byte(1'b1, b);  chk("R4", "read reg5", 64'(b), 64'h11);
    get_byte(1'b1, b);  chk("R7", "read reg6", 64'(b), 64'h5A);
    get_byte(1'b0, b);  chk("R5", "read wrapped reg0", 64'(b), 64'h33);
    chk("R6", "released after nack", 64'(sda_oe), 64'd0);
    get_byte(1'b0, b);  chk("R6", "silent after nack", 64'(b), 64'hFF);
    bus_stop();

    // stop in the middle keeps committed byte (R8)
    bus_start();
    put_byte(8'hD4, a); put_byte(8'h03, a); put_byte(8'h02, a);
    put_byte(8'h99, a);
    bus_stop();
    chk("R8", "committed reg3", 64'(reg_of(3)), 64'h99);
    chk("R8", "reg4 untouched", 64'(reg_of(4)), 64'hFF);

    // start in the middle begins a new transfer (R8)
    bus_start();
    put_byte(8'hD4, a); put_byte(8'h00, a); put_byte(8'h01, a);
    bus_start();
    put_byte(8'hD4, a); chk("R8", "address after restart ack", 64'(a), 64'd1);
    put_byte(8'h04, a); put_byte(8'h01, a);
    put_byte(8'h66, a);
    bus_stop();
    chk("R8", "reg4 from new transfer", 64'(reg_of(4)), 64'h66);
    chk("R8", "reg0 untouched", 64'(reg_of(0)), 64'h33);

    chk("R9", "enable changes during SCL high", 64'(oe_viol), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule